// File: doc/BRIEF.md
# Vector-Chained DMA Transfer Engine

This block is a small DMA engine that serves transfer requests from a handful of peripheral sources. Every source owns one slot in a vector table kept in ordinary RAM. The slot holds the address of the descriptor that currently belongs to that source. When a source asks for service, the engine reads the slot and loads the six-word descriptor it names. It then copies data words from the source address to the destination address and writes the updated progress back into the descriptor.

When a descriptor's count reaches zero, the engine can chain to the next descriptor. It does this by storing the descriptor's link address into the requesting source's vector slot, so the next request from that source starts on a fresh descriptor and the CPU does not have to step in. At the same point it can emit a one-cycle completion interrupt that carries the address of the handler routine. All accesses to descriptors, vectors and data share one request/acknowledge memory port. Vector slots therefore have to live in writable memory.

Top module: `vcdma_top`

## Requirements
- R1: While reset is high, and in the cycle after it, `mem_req_o` and `irq_o` are low.
- R2: A request from source s first reads the word at address `VEC_BASE + s`, and uses that word as the descriptor base. The descriptor layout, as word offsets from the base, is: 0 mode, 1 count, 2 source address, 3 destination address, 4 link address, 5 handler address. The mode bits are: bit 0 chain enable, bit 1 burst, bit 2 interrupt enable.
- R3: With burst clear, a request moves exactly one word from the source address to the destination address. It then writes back the count minus one, the source address plus one and the destination address plus one to descriptor offsets 1, 2 and 3.
- R4: With burst set, a request moves all remaining words to consecutive addresses and writes back a count of zero.
- R5: When the count reaches zero and chain enable is set, the link address is written into the requesting source's vector slot. Otherwise the vector slot is left unchanged.
- R6: After a relink, the next request from that source is served by the descriptor at the link address.
- R7: `irq_o` pulses high for exactly one cycle, with `irq_addr_o` equal to the handler address, only when a request drives the count to zero and interrupt enable is set. The pulse comes in the cycle after the request's last memory write, which is the vector rewrite when chaining.
- R8: A request whose descriptor count is already zero moves no data, writes no memory and raises no interrupt.
- R9: When several sources are pending, they are served one at a time, with the lowest source index first.
- R10: A request that arrives while the engine is serving the same source is held, and it is served once the engine is idle again.
- R11: Once `mem_req_o` is raised, it stays high with a stable address and write flag until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | One-cycle transfer request pulse per source |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | W | Memory word address |
| mem_wdata_o | output | W | Memory write data |
| mem_ack_i | input | 1 | Memory access done; read data valid |
| mem_rdata_i | input | W | Memory read data |
| irq_o | output | 1 | End-of-transfer interrupt pulse |
| irq_addr_o | output | W | Handler address, valid while irq_o is high |

## Verification
The assertions check the following on every cycle: the memory handshake holds its request steady until acknowledged, the interrupt is a single-cycle pulse that directly follows a completed write, the arbiter grants at most one source and always the lowest pending one, and the outputs are quiet after reset. Other behaviour can only be shown by the bench's scenarios, because it appears as memory contents across several requests. This covers the descriptor write-back values, the burst/single split, relinking of the vector slot, fetching of the chained descriptor on the next request, exhausted descriptors being ignored, and held repeat requests. The bench sweeps every mode combination on every source and computes the expected memory image arithmetically.

// File: rtl/vcdma_pkg.sv
package vcdma_pkg;

    localparam int W = 16;

    localparam int MB_CHAIN = 0;
    localparam int MB_BURST = 1;
    localparam int MB_INTE  = 2;

    localparam int OFS_MODE  = 0;
    localparam int OFS_COUNT = 1;
    localparam int OFS_SRC   = 2;
    localparam int OFS_DST   = 3;
    localparam int OFS_LINK  = 4;
    localparam int OFS_ISR   = 5;
    localparam int DESC_WORDS = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_VEC, ST_FETCH, ST_RD, ST_WR, ST_WB, ST_LINK, ST_DONE
    } state_t;

    typedef struct packed {
        logic [2:0]   mode;
        logic [W-1:0] count;
        logic [W-1:0] src;
        logic [W-1:0] dst;
        logic [W-1:0] link;
        logic [W-1:0] isr;
    } desc_t;

    function automatic desc_t desc_load(desc_t d, logic [2:0] idx, logic [W-1:0] v);
        desc_t r;
        r = d;
        case (idx)
            3'(OFS_MODE):  r.mode  = v[2:0];
            3'(OFS_COUNT): r.count = v;
            3'(OFS_SRC):   r.src   = v;
            3'(OFS_DST):   r.dst   = v;
            3'(OFS_LINK):  r.link  = v;
            default:       r.isr   = v;
        endcase
        return r;
    endfunction

    function automatic logic [W-1:0] wb_word(desc_t d, logic [1:0] i);
        case (i)
            2'd0:    return d.count;
            2'd1:    return d.src;
            default: return d.dst;
        endcase
    endfunction

endpackage

// File: rtl/vcdma_pend.sv
module vcdma_pend #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o
);
    always_ff @(posedge clk) begin
        if (rst) pend_o <= '0;
        else     pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/vcdma_arb.sv
module vcdma_arb #(
    parameter int NSRC = 4,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] pend_i,
    output logic [NSRC-1:0] gnt_o,
    output logic [IW-1:0]   idx_o,
    output logic            any_o
);
    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
                idx_o    = IW'(i);
            end
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/vcdma_ctrl.sv
module vcdma_ctrl
    import vcdma_pkg::*;
#(
    parameter int           NSRC     = 4,
    parameter logic [W-1:0] VEC_BASE = '0,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          any_i,
    input  logic [IW-1:0] idx_i,
    output logic          take_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [W-1:0]  mem_addr_o,
    output logic [W-1:0]  mem_wdata_o,
    input  logic          mem_ack_i,
    input  logic [W-1:0]  mem_rdata_i,
    output logic          irq_o,
    output logic [W-1:0]  irq_addr_o
);
    state_t        state;
    logic [IW-1:0] cur;
    logic [W-1:0]  base;
    desc_t         d;
    logic [2:0]    fidx;
    logic [1:0]    wbi;
    logic [W-1:0]  dbuf;
    logic          term;

    assign take_o     = (state == ST_IDLE) && any_i;
    assign irq_o      = (state == ST_DONE) && term && d.mode[MB_INTE];
    assign irq_addr_o = d.isr;

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (state)
            ST_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = VEC_BASE + W'(cur);
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = base + W'(fidx);
            end
            ST_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = d.src;
            end
            ST_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = d.dst;
                mem_wdata_o = dbuf;
            end
            ST_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = base + W'(OFS_COUNT) + W'(wbi);
                mem_wdata_o = wb_word(d, wbi);
            end
            ST_LINK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = VEC_BASE + W'(cur);
                mem_wdata_o = d.link;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            base  <= '0;
            d     <= '0;
            fidx  <= '0;
            wbi   <= '0;
            dbuf  <= '0;
            term  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (any_i) begin
                        cur   <= idx_i;
                        state <= ST_VEC;
                    end
                end
                ST_VEC: begin
                    if (mem_ack_i) begin
                        base  <= mem_rdata_i;
                        fidx  <= '0;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        d <= desc_load(d, fidx, mem_rdata_i);
                        if (fidx == 3'(DESC_WORDS - 1)) begin
                            term  <= 1'b0;
                            state <= (d.count == '0) ? ST_DONE : ST_RD;
                        end else begin
                            fidx <= fidx + 3'd1;
                        end
                    end
                end
                ST_RD: begin
                    if (mem_ack_i) begin
                        dbuf  <= mem_rdata_i;
                        state <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (mem_ack_i) begin
                        d.count <= d.count - 1'b1;
                        d.src   <= d.src + 1'b1;
                        d.dst   <= d.dst + 1'b1;
                        if (d.mode[MB_BURST] && d.count != W'(1)) begin
                            state <= ST_RD;
                        end else begin
                            wbi   <= '0;
                            state <= ST_WB;
                        end
                    end
                end
                ST_WB: begin
                    if (mem_ack_i) begin
                        if (wbi == 2'd2) begin
                            term  <= (d.count == '0);
                            state <= (d.count == '0 && d.mode[MB_CHAIN]) ? ST_LINK : ST_DONE;
                        end else begin
                            wbi <= wbi + 2'd1;
                        end
                    end
                end
                ST_LINK: begin
                    if (mem_ack_i) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vcdma_top.sv
module vcdma_top
    import vcdma_pkg::*;
#(
    parameter int           NSRC     = 4,
    parameter logic [W-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [W-1:0]    mem_addr_o,
    output logic [W-1:0]    mem_wdata_o,
    input  logic            mem_ack_i,
    input  logic [W-1:0]    mem_rdata_i,
    output logic            irq_o,
    output logic [W-1:0]    irq_addr_o
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] gnt_w;
    logic [NSRC-1:0] clr_w;
    logic [IW-1:0]   idx_w;
    logic            any_w;
    logic            take_w;

    assign clr_w = take_w ? gnt_w : '0;

    vcdma_pend #(.NSRC(NSRC)) u_pend (
        .clk(clk), .rst(rst), .set_i(req_i), .clr_i(clr_w), .pend_o(pend_w)
    );

    vcdma_arb #(.NSRC(NSRC)) u_arb (
        .pend_i(pend_w), .gnt_o(gnt_w), .idx_o(idx_w), .any_o(any_w)
    );

    vcdma_ctrl #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_ctrl (
        .clk(clk), .rst(rst), .any_i(any_w), .idx_i(idx_w), .take_o(take_w),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .irq_o(irq_o), .irq_addr_o(irq_addr_o)
    );
endmodule

// File: rtl/vcdma_chk.sv
module vcdma_chk #(
    parameter int NSRC = 4,
    parameter int W    = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_ack,
    input logic [W-1:0]    mem_addr,
    input logic            irq,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] gnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!mem_req && !irq));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_irq_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_ack && mem_we));

    assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt & ~pend) == '0));

    assert_grant_lowest_R9: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0) |-> (((gnt - 1'b1) & pend) == '0));
endmodule

bind vcdma_top vcdma_chk #(.NSRC(NSRC), .W(vcdma_pkg::W)) u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req_o), .mem_we(mem_we_o),
    .mem_ack(mem_ack_i), .mem_addr(mem_addr_o), .irq(irq_o),
    .pend(pend_w), .gnt(gnt_w)
);

// File: tb/sim_vcdma_top.sv
module sim_vcdma_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  req = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;
    logic [15:0] irq_addr;

    logic [15:0] ram [256];
    logic        bd_we = 1'b0;
    logic [7:0]  bd_addr = '0;
    logic [15:0] bd_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    int irq_n = 0;
    logic [15:0] irq_log [16];
    int hs_viol = 0;
    logic        p_pend = 1'b0;
    logic [15:0] p_addr = '0;
    logic        p_we = 1'b0;

    always #5 clk = ~clk;

    vcdma_top #(.NSRC(4), .VEC_BASE(16'h0000)) u0 (
        .clk(clk), .rst(rst), .req_i(req),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .irq_o(irq), .irq_addr_o(irq_addr)
    );

    initial begin
        for (int i = 0; i < 256; i++) ram[i] = '0;
        mem_ack   = 1'b0;
        mem_rdata = '0;
    end

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (bd_we) begin
            ram[bd_addr] <= bd_data;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (irq) begin
                irq_log[irq_n[3:0]] = irq_addr;
                irq_n++;
            end
            if (p_pend && (!mem_req || mem_addr != p_addr || mem_we != p_we)) hs_viol++;
            p_pend = mem_req && !mem_ack;
            p_addr = mem_addr;
            p_we   = mem_we;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bdw(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = v;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        req = m;
        @(negedge clk);
        req = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_case(input int s, input int m);
        int cnt, nreq, base_irq;
        logic chain, burst, inte;
        logic [7:0] d1, d2, sb, db, xd;
        cnt   = 2 + (s % 2);
        chain = m[0]; burst = m[1]; inte = m[2];
        d1 = 8'(8'h20 + s * 16);
        d2 = 8'(8'h28 + s * 16);
        sb = 8'(8'h80 + s * 8);
        db = 8'(8'hC0 + s * 8);
        xd = 8'(8'hF0 + s);
        for (int i = 0; i < 4; i++) bdw(8'(db + i), 16'h0000);
        for (int i = 0; i < cnt; i++) bdw(8'(sb + i), 16'(16'hA000 + s * 256 + m * 16 + i));
        bdw(xd, 16'h0000);
        bdw(d1 + 0, 16'(m));
        bdw(d1 + 1, 16'(cnt));
        bdw(d1 + 2, {8'h00, sb});
        bdw(d1 + 3, {8'h00, db});
        bdw(d1 + 4, {8'h00, d2});
        bdw(d1 + 5, 16'(16'h1000 + s * 16 + m));
        bdw(d2 + 0, 16'h0004);
        bdw(d2 + 1, 16'h0001);
        bdw(d2 + 2, {8'h00, sb});
        bdw(d2 + 3, {8'h00, xd});
        bdw(d2 + 4, 16'h0000);
        bdw(d2 + 5, 16'(16'h2000 + s));
        bdw(8'(s), {8'h00, d1});
        nreq = burst ? 1 : cnt;
        for (int r = 0; r < nreq; r++) begin
            base_irq = irq_n;
            pulse(4'(1 << s));
            settle(80);
            if (!burst) begin
                chk("R3 count write-back", ram[d1 + 1], 16'(cnt - 1 - r));
                chk("R3 source write-back", ram[d1 + 2], 16'(sb + r + 1));
                chk("R3 destination write-back", ram[d1 + 3], 16'(db + r + 1));
                chk("R2/R3 one word moved", ram[db + r], 16'(16'hA000 + s * 256 + m * 16 + r));
                chk("R3 next word untouched", ram[db + r + 1], 16'h0000);
            end
            if (r == nreq - 1) begin
                chk("R7 irq at terminal count", 16'(irq_n - base_irq), inte ? 16'd1 : 16'd0);
                if (inte) chk("R7 handler address", irq_log[4'(irq_n - 1)], 16'(16'h1000 + s * 16 + m));
                chk("R5 vector slot", ram[s], chain ? {8'h00, d2} : {8'h00, d1});
            end else begin
                chk("R7 no irq before terminal", 16'(irq_n - base_irq), 16'd0);
                chk("R5 vector kept before terminal", ram[s], {8'h00, d1});
            end
        end
        if (burst) begin
            chk("R4 count zero after burst", ram[d1 + 1], 16'h0000);
            for (int i = 0; i < cnt; i++)
                chk("R4 burst word", ram[db + i], 16'(16'hA000 + s * 256 + m * 16 + i));
            chk("R4 burst stops at count", ram[db + cnt], 16'h0000);
        end
        base_irq = irq_n;
        pulse(4'(1 << s));
        settle(80);
        if (chain) begin
            chk("R6 chained descriptor moved word", ram[xd], 16'(16'hA000 + s * 256 + m * 16));
            chk("R6 chained descriptor count", ram[d2 + 1], 16'h0000);
            chk("R6 chained irq", 16'(irq_n - base_irq), 16'd1);
            if (irq_n > base_irq) chk("R6 chained handler", irq_log[4'(irq_n - 1)], 16'(16'h2000 + s));
            chk("R6 vector not relinked", ram[s], {8'h00, d2});
        end else begin
            chk("R8 exhausted request moves nothing", ram[xd], 16'h0000);
            chk("R8 exhausted request no irq", 16'(irq_n - base_irq), 16'd0);
            chk("R8 vector unchanged", ram[s], {8'h00, d1});
            chk("R8 count stays zero", ram[d1 + 1], 16'h0000);
            chk("R8 destination tail untouched", ram[db + cnt], 16'h0000);
        end
    endtask

    task automatic prio_test();
        int b;
        for (int s = 0; s < 4; s++) begin
            bdw(8'(8'h20 + s * 16 + 0), 16'h0004);
            bdw(8'(8'h20 + s * 16 + 1), 16'h0001);
            bdw(8'(8'h20 + s * 16 + 2), 16'h0080);
            bdw(8'(8'h20 + s * 16 + 3), 16'(16'h00E0 + s));
            bdw(8'(8'h20 + s * 16 + 5), 16'(16'h3000 + s));
            bdw(8'(s), 16'(16'h0020 + s * 16));
        end
        b = irq_n;
        pulse(4'b1111);
        settle(200);
        chk("R9 all sources served", 16'(irq_n - b), 16'd4);
        for (int k = 0; k < 4; k++)
            chk("R9 service order", irq_log[4'(b + k)], 16'(16'h3000 + k));
    endtask

    task automatic hold_test();
        bdw(8'h40, 16'h0000);
        bdw(8'h41, 16'h0002);
        bdw(8'h42, 16'h0090);
        bdw(8'h43, 16'h00D0);
        bdw(8'h90, 16'h5A01);
        bdw(8'h91, 16'h5A02);
        bdw(8'hD0, 16'h0000);
        bdw(8'hD1, 16'h0000);
        bdw(8'h02, 16'h0040);
        pulse(4'b0100);
        settle(3);
        pulse(4'b0100);
        settle(120);
        chk("R10 held request served, count", ram[8'h41], 16'h0000);
        chk("R10 first word", ram[8'hD0], 16'h5A01);
        chk("R10 second word", ram[8'hD1], 16'h5A02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 mem_req low in reset", {15'd0, mem_req}, 16'd0);
        chk("R1 irq low in reset", {15'd0, irq}, 16'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mem_req low after reset", {15'd0, mem_req}, 16'd0);
        chk("R1 irq low after reset", {15'd0, irq}, 16'd0);
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 8; m++)
                run_case(s, m);
        prio_test();
        hold_test();
        chk("R11 request held until ack", 16'(hs_viol), 16'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule